// File: doc/BRIEF.md
# Variable-Length ADC Bank Unpacker

This block decodes the packed readout of one front-end board. Each bank arrives as a stream of 32-bit words over a valid/ready handshake, and an end marker flags the final word of the bank. The first word of a bank is a length mask with one bit per channel. The words after it carry the 32 channel samples packed back to back. Each sample takes either 4 or 12 bits, as its mask bit selects. The unpacker follows a variable bit cursor across word boundaries. It emits one full 12-bit sample per channel, in ascending channel order, with the channel index and a flag on the final channel.

Malformed banks set a sticky error flag and do not stop the stream. If a bank ends too early, the block emits every sample that arrived complete and then waits for a new mask word. If a bank runs past its expected length, the block decodes it in full and then drops words up to the end marker. Downstream backpressure reaches the input through the ready signal, so no sample is lost or repeated. Once the pipeline has filled, the block decodes one channel per clock.

Top module: `adc_bank_unpacker`

## Requirements
- R1: Bit i of the mask word (bit 0 = channel 0) selects the width of channel i: 1 means a 12-bit long field and 0 means a 4-bit short field. A long field is emitted unchanged.
- R2: The payload starts at bit 0 of the word after the mask and is packed LSB first, channel 0 first. The field's bit 0 is the lowest stream bit. A field that crosses from one word into the next is joined correctly.
- R3: A short field is zero-extended to 12 bits, so bits 11..4 of the sample are 0.
- R4: Samples leave in channel order 0 to 31 and `out_chan` carries the index. `out_last` is 1 exactly on channel 31.
- R5: A well-formed bank holds ceil((128 + 8*popcount(mask)) / 32) payload words, and the end marker sits on the last of them. Unused bits in that word are ignored. The next word is taken as a new mask, and no error is raised.
- R6: If the end marker arrives before the expected word count (this includes a mask word that carries the marker), `bank_err` goes to 1 and stays there until reset. Every channel whose field lies wholly in the delivered words is still emitted, none after it, and `out_last` is not raised. The next word is taken as a mask.
- R7: If the expected last payload word lacks the end marker, all 32 channels are still emitted and `bank_err` goes to 1 and stays there. The following words up to and including the next end-marked word are discarded with no output. The word after that is a mask.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output holds its value. Stalls on either side neither drop nor duplicate a sample. After reset, `out_valid` and `bank_err` are 0.
- R9: With input words always valid and `out_ready` always 1, the 32 samples of a bank leave on 32 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | 32 | Mask or payload word |
| in_last | input | 1 | Marks the final word of a bank |
| out_valid | output | 1 | Decoded sample present |
| out_ready | input | 1 | Downstream accepts the sample |
| out_sample | output | 12 | Decoded ADC value |
| out_chan | output | 5 | Channel index of the sample |
| out_last | output | 1 | Sample belongs to channel 31 |
| bank_err | output | 1 | Sticky malformed-bank flag |

## Verification
The properties assume that a word counts only when `in_valid` and `in_ready` are both high, and that reset is not pulsed in the middle of a run. The error-flag property depends on the second assumption. The bench advances its word pointer only after a completed handshake, and it resets only between phases, where it checks that the flag has cleared. The valid gaps and output stalls are random, and the bank contents come from a fixed seed. Directed banks cover an all-long mask, an all-short mask, single-bit masks, a truncated bank, a mask-only bank and a bank with surplus words.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    localparam int DEF_CHANNELS = 32;
    localparam int DEF_WORD_W   = 32;
    localparam int DEF_LONG_W   = 12;
    localparam int DEF_SHORT_W  = 4;

    typedef enum logic [1:0] {
        ST_MASK = 2'd0,
        ST_DATA = 2'd1,
        ST_SKIP = 2'd2
    } frame_st_e;
endpackage

// File: rtl/unpk_bitbuf.sv
module unpk_bitbuf #(
    parameter int WORD_W  = 32,
    parameter int BUF_W   = 64,
    parameter int FIELD_W = 12,
    parameter int LVL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    input  logic [LVL_W-1:0]  pop_w,
    output logic [FIELD_W-1:0] window,
    output logic [LVL_W-1:0]  level
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [LVL_W-1:0] lvl;
    } buf_t;

    buf_t st_d, st_q;
    logic [LVL_W-1:0] pop_amt;
    logic [LVL_W-1:0] lvl_rest;

    always_comb begin
        pop_amt  = pop ? pop_w : '0;
        lvl_rest = st_q.lvl - pop_amt;
        st_d.bits = st_q.bits >> pop_amt;
        st_d.lvl  = lvl_rest;
        if (push) begin
            st_d.bits = st_d.bits | (BUF_W'(push_word) << lvl_rest);
            st_d.lvl  = lvl_rest + LVL_W'(WORD_W);
        end
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign window = st_q.bits[FIELD_W-1:0];
    assign level  = st_q.lvl;

    // R8: a word is appended only when it fits after this cycle's pop
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.lvl - pop_amt) <= LVL_W'(BUF_W - WORD_W));

    // R2: a field is read only when all of its bits are present
    a_r2_no_underread: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.lvl >= pop_w);
endmodule

// File: rtl/unpk_framer.sv
module unpk_framer
    import unpk_pkg::*;
#(
    parameter int CHANNELS = 32,
    parameter int WORD_W   = 32,
    parameter int LONG_W   = 12,
    parameter int SHORT_W  = 4,
    parameter int BUF_W    = 64,
    parameter int LVL_W    = 7,
    parameter int CHIDX_W  = 5,
    parameter int CHAN_W   = 6,
    parameter int WCNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_last,
    input  logic [LVL_W-1:0]   level,
    input  logic [LONG_W-1:0]  window,
    input  logic               slot_free,
    output logic               in_ready,
    output logic               push,
    output logic               flush,
    output logic               pop,
    output logic [LVL_W-1:0]   pop_w,
    output logic               emit,
    output logic [LONG_W-1:0]  emit_sample,
    output logic [CHIDX_W-1:0] emit_chan,
    output logic               emit_last,
    output logic               err
);
    typedef struct packed {
        frame_st_e           st;
        logic [CHANNELS-1:0] mask;
        logic [CHAN_W-1:0]   chan;
        logic [WCNT_W-1:0]   words_left;
        logic                trunc;
        logic                skip_after;
        logic                err;
    } fr_t;

    fr_t st_d, st_q;
    logic             cur_long;
    logic [LVL_W-1:0] need_w;
    logic [LVL_W-1:0] pop_amt;
    logic             fits;
    logic             room;
    logic             accept;

    function automatic logic [WCNT_W-1:0] words_for(input logic [CHANNELS-1:0] m);
        int ones;
        int bits;
        ones = 0;
        for (int i = 0; i < CHANNELS; i++) begin
            ones = ones + int'(m[i]);
        end
        bits = CHANNELS * SHORT_W + ones * (LONG_W - SHORT_W);
        return WCNT_W'((bits + WORD_W - 1) / WORD_W);
    endfunction

    always_comb begin
        st_d     = st_q;
        cur_long = st_q.mask[st_q.chan[CHIDX_W-1:0]];
        need_w   = cur_long ? LVL_W'(LONG_W) : LVL_W'(SHORT_W);
        fits     = level >= need_w;
        pop      = (st_q.st == ST_DATA) && fits && slot_free;
        pop_amt  = pop ? need_w : '0;
        room     = (level - pop_amt) <= LVL_W'(BUF_W - WORD_W);
        flush    = 1'b0;

        case (st_q.st)
            ST_MASK: in_ready = 1'b1;
            ST_SKIP: in_ready = 1'b1;
            ST_DATA: in_ready = !st_q.trunc && (st_q.words_left != '0) && room;
            default: in_ready = 1'b0;
        endcase
        accept = in_valid && in_ready;
        push   = accept && (st_q.st == ST_DATA);

        case (st_q.st)
            ST_MASK: begin
                if (accept) begin
                    if (in_last) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.mask       = in_data[CHANNELS-1:0];
                        st_d.chan       = '0;
                        st_d.words_left = words_for(in_data[CHANNELS-1:0]);
                        st_d.trunc      = 1'b0;
                        st_d.skip_after = 1'b0;
                        st_d.st         = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (pop) begin
                    st_d.chan = st_q.chan + CHAN_W'(1);
                end
                if (push) begin
                    st_d.words_left = st_q.words_left - WCNT_W'(1);
                    if (in_last && st_q.words_left != WCNT_W'(1)) begin
                        st_d.trunc = 1'b1;
                        st_d.err   = 1'b1;
                    end
                    if (!in_last && st_q.words_left == WCNT_W'(1)) begin
                        st_d.skip_after = 1'b1;
                        st_d.err        = 1'b1;
                    end
                end
                if (pop && st_q.chan == CHAN_W'(CHANNELS - 1)) begin
                    flush   = 1'b1;
                    st_d.st = st_q.skip_after ? ST_SKIP : ST_MASK;
                end else if (st_q.trunc && !fits) begin
                    flush   = 1'b1;
                    st_d.st = ST_MASK;
                end
            end
            ST_SKIP: begin
                if (accept && in_last) begin
                    st_d.st = ST_MASK;
                end
            end
            default: st_d.st = ST_MASK;
        endcase

        pop_w       = need_w;
        emit        = pop;
        emit_sample = cur_long ? window : {{(LONG_W-SHORT_W){1'b0}}, window[SHORT_W-1:0]};
        emit_chan   = st_q.chan[CHIDX_W-1:0];
        emit_last   = st_q.chan == CHAN_W'(CHANNELS - 1);
        err         = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= ST_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the malformed-bank flag never clears on its own
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R4: each emitted channel is followed by the next index
    a_r4_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !emit_last) |=> st_q.chan == $past(st_q.chan) + CHAN_W'(1));

    // R5: the bit buffer is empty whenever a mask word is expected
    a_r5_empty_at_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_MASK) |-> level == '0);
endmodule

// File: rtl/unpk_outstage.sv
module unpk_outstage #(
    parameter int SAMPLE_W = 12,
    parameter int CHIDX_W  = 5,
    parameter int CHANNELS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emit,
    input  logic [SAMPLE_W-1:0] emit_sample,
    input  logic [CHIDX_W-1:0]  emit_chan,
    input  logic                emit_last,
    input  logic                out_ready,
    output logic                slot_free,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [CHIDX_W-1:0]  out_chan,
    output logic                out_last
);
    typedef struct packed {
        logic                v;
        logic [SAMPLE_W-1:0] sample;
        logic [CHIDX_W-1:0]  chan;
        logic                last;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        slot_free = !st_q.v || out_ready;
        st_d      = st_q;
        if (slot_free) begin
            st_d.v      = emit;
            st_d.sample = emit_sample;
            st_d.chan   = emit_chan;
            st_d.last   = emit_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.v;
    assign out_sample = st_q.sample;
    assign out_chan   = st_q.chan;
    assign out_last   = st_q.last;

    // R8: a stalled sample holds still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_chan)));

    // R8: the decoder never emits into an occupied slot
    a_r8_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> slot_free);

    // R4: the last flag only accompanies the top channel
    a_r4_last_top: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_chan == CHIDX_W'(CHANNELS - 1));
endmodule

// File: rtl/adc_bank_unpacker.sv
module adc_bank_unpacker
    import unpk_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int WORD_W   = DEF_WORD_W,
    parameter int LONG_W   = DEF_LONG_W,
    parameter int SHORT_W  = DEF_SHORT_W,
    localparam int CHIDX_W = $clog2(CHANNELS),
    localparam int CHAN_W  = CHIDX_W + 1,
    localparam int BUF_W   = 2 * WORD_W,
    localparam int LVL_W   = $clog2(BUF_W) + 1,
    localparam int MAXWRD  = (CHANNELS * LONG_W + WORD_W - 1) / WORD_W,
    localparam int WCNT_W  = $clog2(MAXWRD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LONG_W-1:0]  out_sample,
    output logic [CHIDX_W-1:0] out_chan,
    output logic               out_last,
    output logic               bank_err
);
    logic               push, flush, pop, emit, emit_last, slot_free;
    logic [LVL_W-1:0]   pop_w, level;
    logic [LONG_W-1:0]  window, emit_sample;
    logic [CHIDX_W-1:0] emit_chan;

    unpk_bitbuf #(
        .WORD_W (WORD_W),
        .BUF_W  (BUF_W),
        .FIELD_W(LONG_W),
        .LVL_W  (LVL_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .push_word(in_data),
        .pop      (pop),
        .pop_w    (pop_w),
        .window   (window),
        .level    (level)
    );

    unpk_framer #(
        .CHANNELS(CHANNELS),
        .WORD_W  (WORD_W),
        .LONG_W  (LONG_W),
        .SHORT_W (SHORT_W),
        .BUF_W   (BUF_W),
        .LVL_W   (LVL_W),
        .CHIDX_W (CHIDX_W),
        .CHAN_W  (CHAN_W),
        .WCNT_W  (WCNT_W)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .level      (level),
        .window     (window),
        .slot_free  (slot_free),
        .in_ready   (in_ready),
        .push       (push),
        .flush      (flush),
        .pop        (pop),
        .pop_w      (pop_w),
        .emit       (emit),
        .emit_sample(emit_sample),
        .emit_chan  (emit_chan),
        .emit_last  (emit_last),
        .err        (bank_err)
    );

    unpk_outstage #(
        .SAMPLE_W(LONG_W),
        .CHIDX_W (CHIDX_W),
        .CHANNELS(CHANNELS)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .emit_sample(emit_sample),
        .emit_chan  (emit_chan),
        .emit_last  (emit_last),
        .out_ready  (out_ready),
        .slot_free  (slot_free),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_chan   (out_chan),
        .out_last   (out_last)
    );
endmodule

// File: tb/adc_bank_unpacker_bench.sv
module adc_bank_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_sample;
    logic [4:0]  out_chan;
    logic        out_last;
    logic        bank_err;

    always #5 clk = ~clk;

    adc_bank_unpacker u_adc_bank_unpacker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_sample(out_sample), .out_chan(out_chan),
        .out_last(out_last), .bank_err(bank_err)
    );

    logic [32:0] stim [0:2047];
    logic [11:0] exp_s [0:2047];
    logic [4:0]  exp_c [0:2047];
    logic        exp_l [0:2047];
    string       exp_t [0:2047];
    int          out_cyc [0:2047];
    int n_stim = 0, sp = 0, n_exp = 0, op = 0, cyc = 0;
    int total = 0, bad = 0;
    logic hs_in = 1'b0, hs_out = 1'b0;
    logic [11:0] cap_s;
    logic [4:0]  cap_c;
    logic        cap_l;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // mode 0 well formed, 1 cut after `cut` payload words, 2 `cut` surplus words, 3 mask word alone
    task automatic add_bank(input logic [31:0] mask, input int mode, input int cut);
        logic [511:0] pk;
        logic [11:0]  vals [32];
        int           ends [32];
        bit           strad [32];
        int pos, words, lim;
        pk = '0;
        pos = 0;
        for (int c = 0; c < 32; c++) begin
            logic [11:0] v;
            int w;
            w = mask[c] ? 12 : 4;
            v = 12'($urandom) & (mask[c] ? 12'hFFF : 12'h00F);
            if (mask[c]) pk[pos +: 12] = v;
            else         pk[pos +: 4]  = v[3:0];
            vals[c]  = v;
            strad[c] = (pos / 32) != ((pos + w - 1) / 32);
            pos += w;
            ends[c] = pos;
        end
        words = (pos + 31) / 32;
        if (mode == 3) begin
            stim[n_stim++] = {1'b1, mask};
        end else begin
            stim[n_stim++] = {1'b0, mask};
            lim = (mode == 1) ? cut : words;
            for (int i = 0; i < lim; i++)
                stim[n_stim++] = {(mode != 2) && (i == lim - 1), pk[i*32 +: 32]};
            if (mode == 2)
                for (int e = 0; e < cut; e++)
                    stim[n_stim++] = {e == cut - 1, 32'($urandom)};
            for (int c = 0; c < 32; c++) begin
                if (mode != 1 || ends[c] <= 32 * lim) begin
                    exp_s[n_exp] = vals[c];
                    exp_c[n_exp] = 5'(c);
                    exp_l[n_exp] = (c == 31);
                    exp_t[n_exp] = strad[c] ? "R2" : (mask[c] ? "R1" : "R3");
                    n_exp++;
                end
            end
        end
    endtask

    task automatic run_phase(input int gap, input int stall);
        int guard;
        guard = 0;
        while ((sp < n_stim || op < n_exp || hs_in || hs_out || out_valid) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (hs_in) sp++;
            if (hs_out) begin
                if (op >= n_exp) begin
                    chk(1'b0, "R4", "unexpected sample on channel", int'(cap_c), -1);
                end else begin
                    chk(cap_s == exp_s[op], exp_t[op], "sample value", int'(cap_s), int'(exp_s[op]));
                    chk(cap_c == exp_c[op], "R4", "channel index", int'(cap_c), int'(exp_c[op]));
                    chk(cap_l == exp_l[op], "R4", "last flag", int'(cap_l), int'(exp_l[op]));
                    out_cyc[op] = cyc;
                    op++;
                end
            end
            in_valid  = (sp < n_stim) && ($urandom_range(99) >= gap);
            in_data   = (sp < n_stim) ? stim[sp][31:0] : 32'h0;
            in_last   = (sp < n_stim) ? stim[sp][32] : 1'b0;
            out_ready = ($urandom_range(99) >= stall);
            #1;
            hs_in  = in_valid && in_ready;
            hs_out = out_valid && out_ready;
            cap_s  = out_sample;
            cap_c  = out_chan;
            cap_l  = out_last;
            cyc++;
        end
        chk(guard < 20000, "R8", "phase drained (outputs seen)", op, n_exp);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        in_valid  = 1'b0;
        out_ready = 1'b0;
        rst_n     = 1'b0;
        hs_in     = 1'b0;
        hs_out    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(bank_err == 1'b0, "R6", "bank_err after reset", int'(bank_err), 0);
        chk(in_ready == 1'b1, "R5", "ready for mask after reset", int'(in_ready), 1);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        do_reset();

        // Phase A: full rate, all-long first for R9
        base = n_exp;
        add_bank(32'hFFFF_FFFF, 0, 0);
        add_bank(32'h0000_0000, 0, 0);
        for (int b = 0; b < 6; b++) add_bank($urandom, 0, 0);
        run_phase(0, 0);
        chk(out_cyc[base + 31] - out_cyc[base] == 31, "R9", "cycles across one bank",
            out_cyc[base + 31] - out_cyc[base], 31);
        chk(bank_err == 1'b0, "R5", "no error on padded banks", int'(bank_err), 0);

        // Phase B: gaps and stalls
        add_bank(32'h0000_0001, 0, 0);
        add_bank(32'h8000_0000, 0, 0);
        add_bank(32'h5555_5555, 0, 0);
        for (int b = 0; b < 8; b++) add_bank($urandom, 0, 0);
        run_phase(30, 45);
        chk(bank_err == 1'b0, "R8", "no error under stalls", int'(bank_err), 0);

        // Phase C: truncated bank, then mask-only bank, each followed by a good one
        add_bank(32'hF0F0_1234, 1, 3);
        add_bank($urandom, 0, 0);
        run_phase(20, 30);
        chk(bank_err == 1'b1, "R6", "error after short bank", int'(bank_err), 1);
        add_bank(32'hABCD_0000, 3, 0);
        add_bank($urandom, 0, 0);
        add_bank($urandom, 1, 1);
        add_bank($urandom, 0, 0);
        run_phase(10, 10);
        chk(bank_err == 1'b1, "R6", "error flag held", int'(bank_err), 1);

        // Phase D: surplus words
        do_reset();
        add_bank($urandom, 0, 0);
        run_phase(0, 0);
        chk(bank_err == 1'b0, "R7", "clean before surplus bank", int'(bank_err), 0);
        add_bank(32'h0F0F_0F0F, 2, 3);
        add_bank($urandom, 0, 0);
        add_bank(32'hFFFF_0000, 2, 1);
        add_bank($urandom, 0, 0);
        run_phase(25, 35);
        chk(bank_err == 1'b1, "R7", "error after surplus words", int'(bank_err), 1);
        chk(op == n_exp, "R7", "all samples after resync", op, n_exp);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule